// File: doc/BRIEF.md
# Hardwired Accumulator Processor Sequencer

This block is a small accumulator processor whose control is fixed logic rather than a stored program. All transfers between the program counter, memory address register, memory data register, instruction register, accumulator and ALU result register pass over one internal bus. In any step only one register drives the bus. The memory sits outside the block behind a plain address, data, read and write interface. The memory data register takes read data at the end of every step that asserts the read strobe.

A one-hot ring of eight timing steps moves forward one position per clock. The opcode lines are decoded during the fourth step and held. Each control strobe is an OR of products that combine one timing step with one held opcode line. Every instruction starts with the same three-step fetch and a decode step. The last step of each opcode returns the ring to its first position.

Top module: `accpu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter and accumulator are cleared to 0 and the ring returns to its first step (`tstate_o` = 8'b0000_0001).
- R2: `tstate_o` always has exactly one bit set. Each clock moves it up by one position, except that an instruction's final step returns it to bit 0.
- R3: Fetch reads memory once at the address held in the program counter, during step 1. At the end of that step the program counter increases by one, modulo 2^AW. Apart from this, the program counter changes only on a taken branch.
- R4: An instruction word is DW bits wide. Bits [DW-1:DW-2] hold the opcode, with 00 = load, 01 = add, 10 = store and 11 = branch-if-zero. Bits [AW-1:0] hold the operand address.
- R5: Load sets ACC to mem[address]. It takes 7 cycles and 2 memory reads.
- R6: Add sets ACC to ACC + mem[address], modulo 2^DW. It takes 8 cycles and 2 memory reads.
- R7: Store writes ACC to mem[address] and leaves ACC unchanged. It takes 7 cycles, 1 read and exactly 1 write. The write is issued in step 6, with `mem_addr` set to the operand address.
- R8: Branch-if-zero loads the operand address into the program counter when ACC is 0. Otherwise the program counter keeps its incremented value. The instruction takes 6 cycles, performs only the fetch read and leaves ACC unchanged.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Memory address, taken from the memory address register |
| mem_rd | output | 1 | Read strobe; data is taken at the end of this cycle |
| mem_wr | output | 1 | Write strobe; memory stores `mem_wdata` at this edge |
| mem_wdata | output | DW | Write data, taken from the memory data register |
| mem_rdata | input | DW | Read data, valid in the cycle `mem_rd` is high |
| pc_o | output | AW | Program counter value |
| acc_o | output | DW | Accumulator value |
| tstate_o | output | 8 | One-hot timing step |

## Verification
An instruction's architectural results are due at the clock edge that returns `tstate_o` to bit 0. That is 6, 7 or 8 edges after its first step, depending on the opcode. The bench waits for that return and samples on the falling edge that follows. There it compares PC, ACC and the written memory word with a bench model. The read address, the write address and the strobe counts are sampled on the falling edge inside each step, in the same cycle as the strobe that produces them.

// File: rtl/accpu_pkg.sv
package accpu_pkg;
  localparam int NSTEP = 8;

  localparam int unsigned OPI_LOAD  = 0;
  localparam int unsigned OPI_ADD   = 1;
  localparam int unsigned OPI_STORE = 2;
  localparam int unsigned OPI_BRZ   = 3;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic pc_incr;
    logic mar_in;
    logic mdr_in;
    logic mdr_out;
    logic ir_in;
    logic ir_out;
    logic acc_in;
    logic acc_out;
    logic alu_add;
    logic tmp_out;
    logic rd;
    logic wr;
    logic last;
  } strobe_t;
endpackage

// File: rtl/accpu_ring.sv
module accpu_ring #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         last,
  output logic [N-1:0] t
);
  localparam logic [N-1:0] FIRST = N'(1);

  always_ff @(posedge clk) begin
    if (rst || last) t <= FIRST;
    else             t <= {t[N-2:0], t[N-1]};
  end
endmodule

// File: rtl/accpu_ctrl.sv
module accpu_ctrl
  import accpu_pkg::*;
#(
  parameter int OPW   = 2,
  parameter int NSTEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTEP-1:0] t,
  input  logic [OPW-1:0]   opcode,
  input  logic             acc_zero,
  output strobe_t          s
);
  localparam int NOP = 1 << OPW;

  logic [NOP-1:0] dec;
  logic [NOP-1:0] dec_q;

  generate
    for (genvar g = 0; g < NOP; g++) begin : g_dec
      assign dec[g] = (opcode == OPW'(g));
    end
  endgenerate

  // opcode lines are latched in the decode step and stay valid through T7
  always_ff @(posedge clk) begin
    if (rst)       dec_q <= '0;
    else if (t[3]) dec_q <= dec;
  end

  logic ld, ad, st, bz, mem_op;
  assign ld     = dec_q[OPI_LOAD];
  assign ad     = dec_q[OPI_ADD];
  assign st     = dec_q[OPI_STORE];
  assign bz     = dec_q[OPI_BRZ];
  assign mem_op = ld | ad | st;

  always_comb begin
    s         = '0;
    s.pc_out  = t[0];
    s.mar_in  = t[0] | (mem_op & t[4]);
    s.rd      = t[1] | ((ld | ad) & t[5]);
    s.pc_incr = t[1];
    s.mdr_out = t[2] | (ld & t[6]);
    s.ir_in   = t[2];
    s.ir_out  = (mem_op & t[4]) | (bz & acc_zero & t[4]);
    s.pc_in   = bz & acc_zero & t[4];
    s.acc_out = (ad & t[6]) | (st & t[5]);
    s.alu_add = ad & t[6];
    s.mdr_in  = st & t[5];
    s.wr      = st & t[6];
    s.tmp_out = ad & t[7];
    s.acc_in  = (ld & t[6]) | (ad & t[7]);
    s.last    = (ld & t[6]) | (ad & t[7]) | (st & t[6]) | (bz & t[5]);
  end
endmodule

// File: rtl/accpu_dp.sv
module accpu_dp
  import accpu_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic          acc_zero
);
  localparam int PADW = DW - AW;

  logic [DW-1:0] bus;
  logic [DW-1:0] tmp;

  // single internal bus: the strobes enable at most one source per step
  always_comb begin
    bus = '0;
    if (s.pc_out)  bus = bus | {{PADW{1'b0}}, pc};
    if (s.ir_out)  bus = bus | {{PADW{1'b0}}, ir[AW-1:0]};
    if (s.mdr_out) bus = bus | mdr;
    if (s.acc_out) bus = bus | acc;
    if (s.tmp_out) bus = bus | tmp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
      tmp <= '0;
    end else begin
      if (s.pc_in)        pc  <= bus[AW-1:0];
      else if (s.pc_incr) pc  <= pc + AW'(1);
      if (s.mar_in)       mar <= bus[AW-1:0];
      if (s.rd)           mdr <= mem_rdata;
      else if (s.mdr_in)  mdr <= bus;
      if (s.ir_in)        ir  <= bus;
      if (s.acc_in)       acc <= bus;
      if (s.alu_add)      tmp <= bus + mdr;
    end
  end

  assign acc_zero = (acc == '0);
endmodule

// File: rtl/accpu_top.sv
module accpu_top
  import accpu_pkg::*;
#(
  parameter int DW  = 12,
  parameter int AW  = 10,
  parameter int OPW = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    pc_o,
  output logic [DW-1:0]    acc_o,
  output logic [NSTEP-1:0] tstate_o
);
  strobe_t          s;
  logic [NSTEP-1:0] t;
  logic [AW-1:0]    pc, mar;
  logic [DW-1:0]    mdr, ir, acc;
  logic             acc_zero;

  accpu_ring #(.N(NSTEP)) u_ring (
    .clk (clk),
    .rst (rst),
    .last(s.last),
    .t   (t)
  );

  accpu_ctrl #(.OPW(OPW), .NSTEP(NSTEP)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .t       (t),
    .opcode  (ir[DW-1 -: OPW]),
    .acc_zero(acc_zero),
    .s       (s)
  );

  accpu_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .s        (s),
    .mem_rdata(mem_rdata),
    .pc       (pc),
    .mar      (mar),
    .mdr      (mdr),
    .ir       (ir),
    .acc      (acc),
    .acc_zero (acc_zero)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = s.rd;
  assign mem_wr    = s.wr;
  assign pc_o      = pc;
  assign acc_o     = acc;
  assign tstate_o  = t;
endmodule

// File: rtl/accpu_chk.sv
module accpu_chk #(
  parameter int DW = 12,
  parameter int AW = 10,
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] acc_o,
  input logic [NS-1:0] tstate_o
);
  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(tstate_o) == 1);                                            // R2
  AST_RING_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !tstate_o[0] |-> tstate_o == ($past(tstate_o) << 1));                   // R2
  AST_PC_INCR_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(tstate_o[1]) |-> pc_o == $past(pc_o) + AW'(1));                   // R3
  AST_PC_CHANGE_WHEN: assert property (@(posedge clk) disable iff (rst)
    (pc_o != $past(pc_o)) |-> ($past(tstate_o[1]) || $past(tstate_o[4])));  // R3
  AST_ACC_CHANGE_WHEN: assert property (@(posedge clk) disable iff (rst)
    (acc_o != $past(acc_o)) |-> ($past(tstate_o[6]) || $past(tstate_o[7]))); // R5
  AST_WR_IN_STEP6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> tstate_o[6]);                                                // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));                                                   // R9
endmodule

bind accpu_top accpu_chk #(.DW(DW), .AW(AW), .NS(accpu_pkg::NSTEP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .pc_o    (pc_o),
  .acc_o   (acc_o),
  .tstate_o(tstate_o)
);

// File: tb/accpu_top_bench.sv
module accpu_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int AW = 10;
  localparam int MSZ = 1 << AW;
  localparam int N_INSTR = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AW-1:0] pc_o;
  logic [DW-1:0] acc_o;
  logic [7:0]    tstate_o;

  logic [DW-1:0] mem     [MSZ];
  logic [DW-1:0] ref_mem [MSZ];
  logic [AW-1:0] mpc;
  logic [DW-1:0] macc;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accpu_top #(.DW(DW), .AW(AW)) u_accpu_top (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_o(pc_o), .acc_o(acc_o),
    .tstate_o(tstate_o)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [1:0] op);
    case (op)
      2'b00: return 7;
      2'b01: return 8;
      2'b10: return 7;
      default: return 6;
    endcase
  endfunction

  function automatic logic [DW-1:0] iword(input logic [1:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic run_one();
    logic [DW-1:0] w;
    logic [1:0]    op;
    logic [AW-1:0] a, first_ra, wa;
    logic [DW-1:0] old_acc;
    string         req;
    int n = 0, rds = 0, wrs = 0, both = 0;
    bit got_ra = 0;
    first_ra = '0;
    wa = '0;
    check("R2", "ring at T0 before instruction", tstate_o, 1);
    do begin
      if (mem_rd && !got_ra) begin first_ra = mem_addr; got_ra = 1; end
      if (mem_rd) rds++;
      if (mem_wr) begin wrs++; wa = mem_addr; end
      if (mem_rd && mem_wr) both++;
      n++;
      @(negedge clk);
    end while (tstate_o != 8'd1 && n < 16);
    // reference model
    w = ref_mem[mpc];
    op = w[DW-1:DW-2];
    a  = w[AW-1:0];
    old_acc = macc;
    check("R3", "fetch address", first_ra, mpc);
    mpc = mpc + AW'(1);
    case (op)
      2'b00: begin macc = ref_mem[a]; req = "R5"; end
      2'b01: begin macc = macc + ref_mem[a]; req = "R6"; end
      2'b10: begin ref_mem[a] = macc; req = "R7"; end
      default: begin if (macc == '0) mpc = a; req = "R8"; end
    endcase
    check(req, "cycle count", n, exp_cycles(op));
    check(req, "read count", rds, (op == 2'b00 || op == 2'b01) ? 2 : 1);
    check(req, "write count", wrs, (op == 2'b10) ? 1 : 0);
    check("R9", "rd/wr overlap cycles", both, 0);
    check((op == 2'b11) ? "R8" : "R3", "pc after instruction", pc_o, mpc);
    check((op == 2'b00) ? "R5" : (op == 2'b01) ? "R6" : "R4", "acc after instruction", acc_o, macc);
    if (op[1]) check(req, "acc unchanged", acc_o, old_acc);
    if (op == 2'b10) begin
      check("R7", "write address", wa, a);
      check("R7", "stored word", mem[a], ref_mem[a]);
    end
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'd1234);
    for (int i = 0; i < MSZ; i++) begin
      r = $urandom;
      mem[i] = (i % 7 == 3) ? '0 : r[DW-1:0];
    end
    // directed corner cases: taken/not taken branch, add wrap, self-modify, PC wrap
    mem[10'h000] = iword(2'b00, 10'h3F0);
    mem[10'h001] = iword(2'b11, 10'h3FB);
    mem[10'h3FB] = iword(2'b01, 10'h3F1);
    mem[10'h3FC] = iword(2'b11, 10'h000);
    mem[10'h3FD] = iword(2'b10, 10'h000);
    mem[10'h3FE] = iword(2'b01, 10'h3F3);
    mem[10'h3FF] = iword(2'b00, 10'h3F1);
    mem[10'h3F0] = 12'h000;
    mem[10'h3F1] = 12'h005;
    mem[10'h3F3] = 12'hFFB;
    mem[10'h005] = 12'h123;
    for (int i = 0; i < MSZ; i++) ref_mem[i] = mem[i];
    mpc  = '0;
    macc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "pc after reset", pc_o, 0);
    check("R1", "acc after reset", acc_o, 0);
    check("R1", "ring after reset", tstate_o, 1);
    for (int k = 0; k < N_INSTR; k++) run_one();
    // R1: reset mid-instruction
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "pc after second reset", pc_o, 0);
    check("R1", "acc after second reset", acc_o, 0);
    check("R1", "ring after second reset", tstate_o, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule